// File: doc/BRIEF.md
# Line-Doubling Scan Converter

This block doubles the line rate of a video stream. It uses two line buffers in turn. One buffer captures the incoming RGB pixels at the base pixel rate. At the same moment the other buffer, which holds the line captured before, is played out two times at twice that rate. Each input line therefore becomes two output lines. Everything runs from a single fast clock. The capture side advances on a clock enable that toggles every cycle, so it runs at half the clock rate. The replay side advances on every cycle.

An input line starts at the rising edge of the horizontal sync. At that edge the two buffers exchange roles, and the replay of the line just captured begins. The block measures the distance between input syncs. Half of the last measured period later, it starts the second replay of the same line. Each replay begins with a one-cycle output line sync. Pixel data leaves through a register, so the output never shows RAM settling. Replayed pixels beyond the line length are black. The output stays black until a complete line has been captured.

Top module: `scan_doubler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rgb_o` is zero and `lsync_o` is low. Reset leaves both address counters at zero and selects buffer 0 for capture.
- R2: A rising edge of `hsync_i` sets the capture phase to "skip". A pixel on `rgb_i` is stored only in a cycle where the phase is "take" and `pix_stb_i` is high. The phase alternates every cycle, so after a sync edge in cycle k the candidate capture cycles are k+2, k+4, and so on. Each stored pixel goes to the next address.
- R3: Every rising edge of `hsync_i` swaps the buffers. The line just captured is the one replayed from the next cycle on, and new pixels go into the other buffer.
- R4: During a replay the read address advances by one on every clock. Consecutive stored pixels therefore appear on `rgb_o` in consecutive cycles.
- R5: A replay starts at each sync edge (cycle k). A second replay starts in cycle k+floor(P/2), where P is the number of cycles between the two previous sync edges. The second replay is skipped while no period has been measured. When the input period is steady, every input line produces exactly two `lsync_o` pulses.
- R6: For a replay that starts in cycle s, `lsync_o` is high in cycle s+2, and the stored pixel 0 appears on `rgb_o` in that same cycle.
- R7: `rgb_o` stays zero until a sync edge ends a line in which all LINE_LEN pixels were stored.
- R8: Pixels offered after LINE_LEN have been stored in a line are discarded. Once a replay has shown LINE_LEN pixels, `rgb_o` is zero until the next replay starts.
- R9: Only the rising edge of `hsync_i` counts. A sync held high for several cycles swaps the buffers and restarts the replay once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock. Replay runs at this rate and capture at half of it. |
| rst_i | input | 1 | Synchronous reset, active high |
| pix_stb_i | input | 1 | Input pixel is valid |
| rgb_i | input | DATA_W | Input RGB pixel |
| hsync_i | input | 1 | Input horizontal sync. Its rising edge starts a line. |
| rgb_o | output | DATA_W | Registered output RGB pixel |
| lsync_o | output | 1 | One-cycle line sync at the doubled line rate |

## Verification
A sync edge in cycle k takes effect at the clock edge that ends cycle k. The new replay address is in place in cycle k+1, and both its first pixel and its sync pulse leave the output register in cycle k+2. The second replay follows the same two-cycle delay, counted from its midpoint cycle. A pixel stored at the edge ending cycle c can be seen only after the next sync swaps it into the replay buffer. The bench model updates at the same rising edge as the design and uses only the inputs. The bench compares the outputs at the following falling edge, one settled cycle later. The per-line pulse count is tallied over the whole window between sync edges, so it does not depend on where the pulses fall inside that window.

// File: rtl/sd_pkg.sv
`timescale 1ns/1ps
package sd_pkg;

    // Which of the two line buffers a role refers to.
    typedef enum logic {
        BUF0 = 1'b0,
        BUF1 = 1'b1
    } buf_sel_e;

    function automatic buf_sel_e other_buf(input buf_sel_e b);
        return (b == BUF0) ? BUF1 : BUF0;
    endfunction

endpackage

// File: rtl/sd_line_ram.sv
`timescale 1ns/1ps
module sd_line_ram #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    // Asynchronous read. The top registers the value before it leaves the block.
    always_comb begin
        if (int'(raddr_i) < DEPTH) begin
            rdata_o = mem_q[raddr_i];
        end else begin
            rdata_o = '0;
        end
    end

endmodule

// File: rtl/sd_wr_side.sv
`timescale 1ns/1ps
module sd_wr_side import sd_pkg::*; #(
    parameter int LINE_LEN = 32,
    parameter int ADDR_W   = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              hs_rise_i,
    input  logic              pix_stb_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output buf_sel_e          wsel_o,
    output logic              primed_o
);

    localparam logic [ADDR_W-1:0] FULL = ADDR_W'(LINE_LEN);

    typedef struct packed {
        logic [ADDR_W-1:0] waddr;
        logic              phase;   // 1: this cycle may take a pixel
        buf_sel_e          wsel;
        logic              primed;
    } wr_st_t;

    wr_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        wr_en_o = !hs_rise_i && cur_q.phase && pix_stb_i && (cur_q.waddr < FULL);
        if (hs_rise_i) begin
            nxt_d.primed = cur_q.primed | (cur_q.waddr == FULL);
            nxt_d.wsel   = other_buf(cur_q.wsel);
            nxt_d.waddr  = '0;
            nxt_d.phase  = 1'b0;
        end else begin
            nxt_d.phase = ~cur_q.phase;
            if (wr_en_o) begin
                nxt_d.waddr = cur_q.waddr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q.waddr  <= '0;
            cur_q.phase  <= 1'b0;
            cur_q.wsel   <= BUF0;
            cur_q.primed <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wr_addr_o = cur_q.waddr;
    assign wsel_o    = cur_q.wsel;
    assign primed_o  = cur_q.primed;

endmodule

// File: rtl/sd_rd_side.sv
`timescale 1ns/1ps
module sd_rd_side #(
    parameter int LINE_LEN   = 32,
    parameter int ADDR_W     = 6,
    parameter int MAX_PERIOD = 1023,
    parameter int TMR_W      = 10
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              hs_rise_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rd_act_o,
    output logic              restart_o,
    output logic              line_start_o
);

    localparam logic [ADDR_W-1:0] FULL = ADDR_W'(LINE_LEN);
    localparam logic [TMR_W-1:0]  TMAX = TMR_W'(MAX_PERIOD);

    typedef struct packed {
        logic [ADDR_W-1:0] raddr;
        logic [TMR_W-1:0]  tmr;    // cycles since the last sync edge, minus one
        logic [TMR_W-1:0]  half;   // half of the last measured period
        logic              start;  // a replay started at the previous edge
    } rd_st_t;

    rd_st_t cur_q, nxt_d;
    logic   mid;
    logic [TMR_W:0] period;

    always_comb begin
        nxt_d     = cur_q;
        period    = {1'b0, cur_q.tmr} + 1'b1;
        mid       = !hs_rise_i && (cur_q.half != '0) && (cur_q.tmr == cur_q.half - 1'b1);
        restart_o = hs_rise_i || mid;
        nxt_d.start = restart_o;
        if (hs_rise_i) begin
            nxt_d.half = TMR_W'(period >> 1);
            nxt_d.tmr  = '0;
        end else if (cur_q.tmr != TMAX) begin
            nxt_d.tmr = cur_q.tmr + 1'b1;
        end
        if (restart_o) begin
            nxt_d.raddr = '0;
        end else if (cur_q.raddr < FULL) begin
            nxt_d.raddr = cur_q.raddr + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_addr_o    = cur_q.raddr;
    assign rd_act_o     = cur_q.raddr < FULL;
    assign line_start_o = cur_q.start;

endmodule

// File: rtl/scan_doubler.sv
`timescale 1ns/1ps
module scan_doubler import sd_pkg::*; #(
    parameter int DATA_W     = 12,
    parameter int LINE_LEN   = 32,
    parameter int MAX_PERIOD = 1023
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              pix_stb_i,
    input  logic [DATA_W-1:0] rgb_i,
    input  logic              hsync_i,
    output logic [DATA_W-1:0] rgb_o,
    output logic              lsync_o
);

    localparam int ADDR_W = $clog2(LINE_LEN + 1);
    localparam int IDX_W  = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam int TMR_W  = $clog2(MAX_PERIOD + 1);

    typedef struct packed {
        logic              hs_prev;
        logic [DATA_W-1:0] rgb;
        logic              lsync;
    } top_st_t;

    top_st_t cur_q, nxt_d;

    logic              hs_rise;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    buf_sel_e          wsel;
    logic              primed;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_act;
    logic              restart;
    logic              line_start;
    logic [DATA_W-1:0] rdata [2];
    logic [DATA_W-1:0] rd_data;

    assign hs_rise = hsync_i & ~cur_q.hs_prev;

    sd_wr_side #(.LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W)) u_wr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .hs_rise_i (hs_rise),
        .pix_stb_i (pix_stb_i),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wsel_o    (wsel),
        .primed_o  (primed)
    );

    sd_rd_side #(
        .LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W), .MAX_PERIOD(MAX_PERIOD), .TMR_W(TMR_W)
    ) u_rd (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .hs_rise_i    (hs_rise),
        .rd_addr_o    (rd_addr),
        .rd_act_o     (rd_act),
        .restart_o    (restart),
        .line_start_o (line_start)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam buf_sel_e BANK = (b == 0) ? BUF0 : BUF1;
        sd_line_ram #(.DATA_W(DATA_W), .DEPTH(LINE_LEN), .IDX_W(IDX_W)) u_ram (
            .clk_i   (clk_i),
            .we_i    (wr_en && (wsel == BANK)),
            .waddr_i (wr_addr[IDX_W-1:0]),
            .wdata_i (rgb_i),
            .raddr_i (rd_addr[IDX_W-1:0]),
            .rdata_o (rdata[b])
        );
    end

    // The replay buffer is always the one not being captured.
    assign rd_data = (wsel == BUF0) ? rdata[1] : rdata[0];

    always_comb begin
        nxt_d         = cur_q;
        nxt_d.hs_prev = hsync_i;
        nxt_d.rgb     = (primed && rd_act) ? rd_data : '0;
        nxt_d.lsync   = line_start;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rgb_o   = cur_q.rgb;
    assign lsync_o = cur_q.lsync;

endmodule

// File: rtl/sd_checker.sv
`timescale 1ns/1ps
module sd_checker #(
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 6,
    parameter int LINE_LEN = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              hs_rise,
    input logic              wr_en,
    input logic              wsel,
    input logic              restart,
    input logic              primed,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rgb
);

    localparam logic [ADDR_W-1:0] FULL = ADDR_W'(LINE_LEN);

    // R2: capture never happens on two cycles in a row
    p_half_rate_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R3: each sync edge exchanges the buffer roles
    p_swap_r3: assert property (@(posedge clk) disable iff (rst)
        hs_rise |=> (wsel != $past(wsel)));

    // R4: replay address steps by one per clock
    p_rd_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!restart && rd_addr < FULL) |=> (rd_addr == $past(rd_addr) + 1'b1));

    // R5: a replay start resets the read address
    p_restart_r5: assert property (@(posedge clk) disable iff (rst)
        restart |=> (rd_addr == '0));

    // R7: black output before a full line exists
    p_black_r7: assert property (@(posedge clk) disable iff (rst)
        !primed |-> (rgb == '0));

    // R8: capture address never passes the line length
    p_wr_bound_r8: assert property (@(posedge clk) disable iff (rst)
        wr_addr <= FULL);

endmodule

bind scan_doubler sd_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN)
) u_sd_checker (
    .clk     (clk_i),
    .rst     (rst_i),
    .hs_rise (hs_rise),
    .wr_en   (wr_en),
    .wsel    (wsel),
    .restart (restart),
    .primed  (primed),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rgb     (rgb_o)
);

// File: tb/test_scan_doubler.sv
`timescale 1ns/1ps
module test_scan_doubler;

    localparam int CLK_PERIOD = 32;
    localparam int DATA_W     = 12;
    localparam int LINE_LEN   = 32;
    localparam int MAX_PERIOD = 1023;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst;
    logic              pix_stb;
    logic [DATA_W-1:0] rgb_in;
    logic              hsync;
    logic [DATA_W-1:0] rgb_o;
    logic              lsync_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;
    string stim_tag = "R2";
    int lineno = 0;
    int sync_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_doubler #(.DATA_W(DATA_W), .LINE_LEN(LINE_LEN), .MAX_PERIOD(MAX_PERIOD)) i_scan_doubler (
        .clk_i     (clk),
        .rst_i     (rst),
        .pix_stb_i (pix_stb),
        .rgb_i     (rgb_in),
        .hsync_i   (hsync),
        .rgb_o     (rgb_o),
        .lsync_o   (lsync_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: plain integers and arrays, updated at each rising edge.
    logic [DATA_W-1:0] mb [2][LINE_LEN];
    int m_hsp, m_ws, m_wc, m_ph, m_tmr, m_half, m_rc, m_start, m_primed;
    int exp_rgb, exp_sync;
    string exp_tag;

    initial begin
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < LINE_LEN; i++) mb[b][i] = '0;
        exp_rgb = 0; exp_sync = 0; exp_tag = "R1";
    end

    always @(posedge clk) begin
        live <= 1'b1;
        if (rst) begin
            m_hsp = 0; m_ws = 0; m_wc = 0; m_ph = 0; m_tmr = 0; m_half = 0;
            m_rc = 0; m_start = 0; m_primed = 0;
            exp_rgb = 0; exp_sync = 0; exp_tag = "R1";
        end else begin
            bit rise, mid;
            rise = hsync && (m_hsp == 0);
            if (m_primed == 0)          exp_tag = "R7";
            else if (m_rc >= LINE_LEN)  exp_tag = "R8";
            else if (m_rc == 0)         exp_tag = "R3";
            else                        exp_tag = "R4";
            exp_rgb  = (m_primed != 0 && m_rc < LINE_LEN) ? int'(mb[1-m_ws][m_rc]) : 0;
            exp_sync = m_start;
            if (!rise && m_ph == 1 && pix_stb && m_wc < LINE_LEN) begin
                mb[m_ws][m_wc] = rgb_in;
                m_wc++;
            end
            mid = !rise && m_half > 0 && m_tmr == m_half - 1;
            m_start = 0;
            if (rise) begin
                if (m_wc == LINE_LEN) m_primed = 1;
                m_ws = 1 - m_ws; m_wc = 0; m_ph = 0;
                m_half = (m_tmr + 1) / 2; m_tmr = 0;
                m_rc = 0; m_start = 1;
            end else begin
                m_ph = 1 - m_ph;
                if (m_tmr < MAX_PERIOD) m_tmr++;
                if (mid) begin
                    m_rc = 0; m_start = 1;
                end else if (m_rc < LINE_LEN) begin
                    m_rc++;
                end
            end
            m_hsp = hsync ? 1 : 0;
        end
    end

    // Compare on every clock, half a period after the edge.
    always @(negedge clk) begin
        if (live && !done) begin
            check(rgb_o == DATA_W'(exp_rgb), {exp_tag, "/", stim_tag}, "rgb_o", int'(rgb_o), exp_rgb);
            check(lsync_o == exp_sync[0], "R6", "lsync_o", int'(lsync_o), exp_sync);
        end
    end

    task automatic run_line(input int period, input int hs_len, input bit gated,
                            input bit expect_two, input string tag);
        for (int c = 0; c < period; c++) begin
            @(negedge clk);
            if (c == 0) begin
                if (expect_two)
                    check(sync_cnt == 2, "R5", "lsync pulses per input line", sync_cnt, 2);
                sync_cnt = 0;
                stim_tag = tag;
            end
            if (lsync_o) sync_cnt++;
            hsync   = (c < hs_len);
            pix_stb = gated ? ((c % 8) < 4) : 1'b1;
            rgb_in  = DATA_W'(lineno * 128 + c);
        end
        lineno++;
    endtask

    initial begin
        rst = 1'b1; pix_stb = 1'b0; rgb_in = '0; hsync = 1'b0;
        repeat (3) @(negedge clk);
        check(rgb_o == '0, "R1", "rgb_o in reset", int'(rgb_o), 0);
        check(lsync_o == 1'b0, "R1", "lsync_o in reset", int'(lsync_o), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rgb_o == '0, "R1", "rgb_o after reset", int'(rgb_o), 0);
        repeat (3) @(negedge clk);

        run_line(20, 1, 1'b0, 1'b0, "R7");   // short line: stays black
        run_line(80, 1, 1'b0, 1'b0, "R8");   // first full line, excess discarded
        run_line(80, 1, 1'b0, 1'b1, "R3");
        run_line(80, 1, 1'b0, 1'b1, "R4");
        run_line(80, 1, 1'b1, 1'b1, "R2");   // gated strobe
        run_line(80, 4, 1'b0, 1'b1, "R9");   // sync held high
        run_line(100, 1, 1'b0, 1'b1, "R5");
        run_line(70, 1, 1'b0, 1'b1, "R5");
        run_line(90, 2, 1'b1, 1'b1, "R9");
        run_line(80, 1, 1'b0, 1'b1, "R6");
        run_line(80, 1, 1'b0, 1'b1, "R8");
        run_line(120, 0, 1'b0, 1'b0, "R8");  // no further sync: replay then idles black
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R5 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule